// File: doc/BRIEF.md
# Single-Operand ALU with Flag Generation

This block is the one-operand execution unit of a 16-bit processor. It takes an operand, the current carry flag, a byte-mode select and a 4-bit operation code, and in the same cycle returns the result, new N, Z, V and C values, a write enable for each flag and a write enable for the result. A flag whose enable is low must keep its old value in the flag register. Operand fetch, addressing and write-back belong to the surrounding datapath.

The operation code is `{group[1:0], sub[1:0]}`. Group 0 holds clear, complement, increment and decrement (sub 0..3). Group 1 holds negate, add-carry, subtract-carry and test. Group 2 holds rotate right, rotate left, arithmetic shift right and shift left. Group 3 is reserved. In byte mode the operation works on the low 8 bits, and the upper byte of the operand passes through.

Top module: `uop_alu`

## Requirements
- R1: Clear (op 0x0) yields result 0 and writes N=0, Z=1, V=0, C=0.
- R2: Complement (op 0x1) yields the bitwise inverse and writes V=0, C=1, with N and Z taken from the result.
- R3: Increment (op 0x2) and decrement (op 0x3) write N, Z and V but leave C unwritten. Increment's V is set only when the result is the most negative value (0x8000, byte 0x80). Decrement's V is set only when the result is the most positive value (0x7FFF, byte 0x7F).
- R4: Negate (op 0x4) yields the two's complement. V is set when the result is the most negative value, and C is set when the result is nonzero.
- R5: Add-carry (op 0x5) yields operand plus C. V = (result is most negative) and C, and the new C = Z and C.
- R6: Subtract-carry (op 0x6) yields operand minus C. V = (operand is most negative) and C, and the new C = C and (operand is zero).
- R7: Test (op 0x7) writes N and Z from the operand, writes V=0 and C=0, holds the result enable low and returns the operand unchanged.
- R8: Rotate right (op 0x8) shifts C into the MSB and bit 0 into C. Rotate left (op 0x9) shifts C into bit 0 and the MSB into C.
- R9: Arithmetic shift right (op 0xA) keeps the sign bit and moves bit 0 into C. Shift left (op 0xB) fills bit 0 with 0 and moves the MSB into C.
- R10: For ops 0x8..0xB all four flags are written, and V = N xor C.
- R11: With byte_mode_i high, MSB is bit 7, Z looks only at bits 7:0, and result bits 15:8 equal operand bits 15:8.
- R12: Reserved ops 0xC..0xF write nothing: all enables are low, the result equals the operand, and all flag outputs are 0.
- R13: For every op except the reserved ones, N and Z are written and equal the lane MSB and lane-is-zero of the result. flag_we_o bit order is [3]=N, [2]=Z, [1]=V, [0]=C. A flag output whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Operand value |
| carry_i | input | 1 | Current C flag |
| byte_mode_i | input | 1 | 1 = operate on bits 7:0 |
| op_i | input | 4 | {group, sub} operation code |
| result_o | output | 16 | Result value |
| result_we_o | output | 1 | Result should be written back |
| flag_n_o | output | 1 | New N |
| flag_z_o | output | 1 | New Z |
| flag_v_o | output | 1 | New V |
| flag_c_o | output | 1 | New C |
| flag_we_o | output | 4 | Flag write enables {N,Z,V,C} |

## Verification
All outputs are combinational, so every result is due in the same cycle as its stimulus, with zero register stages. The bench applies each vector on a rising clock edge and samples all outputs on the following falling edge, half a period later, so that nothing has to race the edge. It sweeps every op and both carry values over every low byte in byte mode, with varied upper bytes, and over boundary and pseudo-random words in word mode. The expected values come from an arithmetic model that uses masks and integer sums.

// File: rtl/uop_alu_pkg.sv
// Package: shared operation codes and field positions of the one-operand ALU.
// Assumes op code = {group[1:0], sub[1:0]}.
package uop_alu_pkg;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int FLAGS_W = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

    typedef enum logic [3:0] {
        OP_CLR = 4'h0, OP_COM = 4'h1, OP_INC = 4'h2, OP_DEC = 4'h3,
        OP_NEG = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_TST = 4'h7,
        OP_ROR = 4'h8, OP_ROL = 4'h9, OP_ASR = 4'hA, OP_ASL = 4'hB
    } op_e;

    localparam logic [1:0] GRP_SHIFT = 2'd2;
    localparam logic [1:0] GRP_RSVD  = 2'd3;
endpackage

// File: rtl/uop_arith.sv
// Module: arithmetic/logic half of a lane (groups 0 and 1) at width W.
// Produces result, V, C and their enables. N/Z are formed by the lane.
module uop_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    input  logic [2:0]   sel_i,
    output logic [W-1:0] res_o,
    output logic         v_o,
    output logic         c_o,
    output logic         we_c_o,
    output logic         res_we_o
);
    import uop_alu_pkg::*;

    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cin_w;
    assign cin_w = {{(W-1){1'b0}}, cin_i};

    // Per-operation result and V/C rules.
    always_comb begin
        res_o    = x_i;
        v_o      = 1'b0;
        c_o      = 1'b0;
        we_c_o   = 1'b1;
        res_we_o = 1'b1;
        case (sel_i)
            3'd0: res_o = '0;
            3'd1: begin
                res_o = ~x_i;
                c_o   = 1'b1;
            end
            3'd2: begin
                res_o  = x_i + ONE;
                v_o    = (res_o == MIN_NEG);
                we_c_o = 1'b0;
            end
            3'd3: begin
                res_o  = x_i - ONE;
                v_o    = (res_o == MAX_POS);
                we_c_o = 1'b0;
            end
            3'd4: begin
                res_o = ~x_i + ONE;
                v_o   = (res_o == MIN_NEG);
                c_o   = (res_o != '0);
            end
            3'd5: begin
                res_o = x_i + cin_w;
                v_o   = (res_o == MIN_NEG) && cin_i;
                c_o   = (res_o == '0) && cin_i;
            end
            3'd6: begin
                res_o = x_i - cin_w;
                v_o   = (x_i == MIN_NEG) && cin_i;
                c_o   = (x_i == '0) && cin_i;
            end
            default: res_we_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/uop_shift.sv
// Module: shift/rotate half of a lane (group 2) at width W.
// Assumes W >= 2. All four ops write C.
module uop_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    input  logic [1:0]   sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    // Select the shifted value and the bit falling out.
    always_comb begin
        case (sub_i)
            2'd0: begin
                res_o = {cin_i, x_i[W-1:1]};
                c_o   = x_i[0];
            end
            2'd1: begin
                res_o = {x_i[W-2:0], cin_i};
                c_o   = x_i[W-1];
            end
            2'd2: begin
                res_o = {x_i[W-1], x_i[W-1:1]};
                c_o   = x_i[0];
            end
            default: begin
                res_o = {x_i[W-2:0], 1'b0};
                c_o   = x_i[W-1];
            end
        endcase
    end
endmodule

// File: rtl/uop_lane.sv
// Module: one complete ALU lane at width W; joins both halves and forms
// N, Z and every enable. Unwritten flag outputs are driven 0.
module uop_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o,
    output logic         res_we_o,
    output logic [3:0]   flags_o,
    output logic [3:0]   we_o
);
    import uop_alu_pkg::*;

    logic [W-1:0] a_res, s_res;
    logic         a_v, a_c, a_we_c, a_res_we, s_c;
    logic [1:0]   grp;
    logic         n_bit, z_bit, v_bit, c_bit;

    assign grp = op_i[3:2];

    uop_arith #(.W(W)) u_arith (
        .x_i(x_i), .cin_i(cin_i), .sel_i(op_i[2:0]),
        .res_o(a_res), .v_o(a_v), .c_o(a_c),
        .we_c_o(a_we_c), .res_we_o(a_res_we)
    );

    uop_shift #(.W(W)) u_shift (
        .x_i(x_i), .cin_i(cin_i), .sub_i(op_i[1:0]),
        .res_o(s_res), .c_o(s_c)
    );

    // Route the selected half and its enables to the lane outputs.
    always_comb begin
        if (grp == GRP_RSVD) begin
            res_o    = x_i;
            res_we_o = 1'b0;
            we_o     = '0;
            c_bit    = 1'b0;
            v_bit    = 1'b0;
        end else if (grp == GRP_SHIFT) begin
            res_o    = s_res;
            res_we_o = 1'b1;
            we_o     = 4'b1111;
            c_bit    = s_c;
            v_bit    = s_res[W-1] ^ s_c;
        end else begin
            res_o    = a_res;
            res_we_o = a_res_we;
            we_o     = {3'b111, a_we_c};
            c_bit    = a_c & a_we_c;
            v_bit    = a_v;
        end
    end

    // Sign and zero detection on the lane result.
    always_comb begin
        n_bit = res_o[W-1] & we_o[FN];
        z_bit = (res_o == '0) & we_o[FZ];
        flags_o = {n_bit, z_bit, v_bit, c_bit};
    end
endmodule

// File: rtl/uop_alu.sv
// Module: top of the one-operand ALU. Builds a word lane and a byte lane,
// picks one by byte_mode_i, and keeps the upper byte in byte mode.
// Assumes purely combinational use inside the execute stage.
module uop_alu (
    input  logic [15:0] operand_i,
    input  logic        carry_i,
    input  logic        byte_mode_i,
    input  logic [3:0]  op_i,
    output logic [15:0] result_o,
    output logic        result_we_o,
    output logic        flag_n_o,
    output logic        flag_z_o,
    output logic        flag_v_o,
    output logic        flag_c_o,
    output logic [3:0]  flag_we_o
);
    import uop_alu_pkg::*;

    localparam int NLANE = 2;

    logic [DATA_W-1:0]  lane_res   [NLANE];
    logic               lane_rwe   [NLANE];
    logic [FLAGS_W-1:0] lane_flags [NLANE];
    logic [FLAGS_W-1:0] lane_we    [NLANE];

    // Lane 0 is full word width, lane 1 is byte width.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W : BYTE_W;
        logic [LW-1:0] res_l;
        uop_lane #(.W(LW)) u_lane (
            .x_i(operand_i[LW-1:0]), .cin_i(carry_i), .op_i(op_i),
            .res_o(res_l), .res_we_o(lane_rwe[g]),
            .flags_o(lane_flags[g]), .we_o(lane_we[g])
        );
        if (LW == DATA_W) begin : g_full
            assign lane_res[g] = res_l;
        end else begin : g_part
            assign lane_res[g] = {operand_i[DATA_W-1:LW], res_l};
        end
    end

    // Choose the lane that matches the operand size.
    always_comb begin
        int sel;
        sel = byte_mode_i ? 1 : 0;
        result_o    = lane_res[sel];
        result_we_o = lane_rwe[sel];
        flag_we_o   = lane_we[sel];
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o} = lane_flags[sel];
    end
endmodule

// File: rtl/uop_alu_checker.sv
// Checker: relational properties between the ALU ports, bound to uop_alu.
module uop_alu_checker (
    input logic [15:0] operand_i,
    input logic        carry_i,
    input logic        byte_mode_i,
    input logic [3:0]  op_i,
    input logic [15:0] result_o,
    input logic        result_we_o,
    input logic        flag_n_o,
    input logic        flag_z_o,
    input logic        flag_v_o,
    input logic        flag_c_o,
    input logic [3:0]  flag_we_o
);
    logic lane_zero, lane_msb;
    assign lane_zero = byte_mode_i ? (result_o[7:0] == 8'h00) : (result_o == 16'h0000);
    assign lane_msb  = byte_mode_i ? result_o[7] : result_o[15];

    // Port-level consistency checks.
    always_comb begin
        if (op_i == 4'h0)
            AST_CLEAR_FLAGS: assert (flag_z_o && !flag_n_o && !flag_v_o && !flag_c_o && lane_zero); // R1
        if (op_i == 4'h7)
            AST_TEST_NO_WRITE: assert (!result_we_o && result_o == operand_i); // R7
        if (op_i[3:2] == 2'd2)
            AST_SHIFT_V_RULE: assert (flag_we_o == 4'hF && flag_v_o == (flag_n_o ^ flag_c_o)); // R10
        if (byte_mode_i)
            AST_UPPER_KEPT: assert (result_o[15:8] == operand_i[15:8]); // R11
        if (op_i[3:2] == 2'd3)
            AST_RSVD_QUIET: assert (flag_we_o == 4'h0 && !result_we_o && result_o == operand_i); // R12
        if (op_i[3:2] != 2'd3)
            AST_NZ_FROM_RESULT: assert (flag_z_o == lane_zero && flag_n_o == lane_msb); // R13
        if (op_i == 4'h2 || op_i == 4'h3)
            AST_INCDEC_KEEP_C: assert (!flag_we_o[0] && carry_i == carry_i); // R3
    end
endmodule

bind uop_alu uop_alu_checker u_uop_alu_checker (
    .operand_i(operand_i), .carry_i(carry_i), .byte_mode_i(byte_mode_i),
    .op_i(op_i), .result_o(result_o), .result_we_o(result_we_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
    .flag_c_o(flag_c_o), .flag_we_o(flag_we_o)
);

// File: tb/uop_alu_bench.sv
// Bench: sweeps every op over byte and word operands against an
// arithmetic model; outputs sampled half a period after each drive.
module uop_alu_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [15:0] operand;
    logic        carry, bmode;
    logic [3:0]  op;
    logic [15:0] result;
    logic        rwe, fn, fz, fv, fc;
    logic [3:0]  fwe;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    uop_alu u_uop_alu (
        .operand_i(operand), .carry_i(carry), .byte_mode_i(bmode), .op_i(op),
        .result_o(result), .result_we_o(rwe), .flag_n_o(fn), .flag_z_o(fz),
        .flag_v_o(fv), .flag_c_o(fc), .flag_we_o(fwe)
    );

    function automatic string req_of(input logic [3:0] o, input logic b);
        if (o >= 4'hC) return "R12";
        if (b && o[0]) return "R11/R13";
        case (o)
            4'h0: return "R1";  4'h1: return "R2";
            4'h2: return "R3";  4'h3: return "R3";
            4'h4: return "R4";  4'h5: return "R5";
            4'h6: return "R6";  4'h7: return "R7";
            4'h8: return "R8/R10";  4'h9: return "R8/R10";
            default: return "R9/R10";
        endcase
    endfunction

    // Expected {result[15:0], rwe, we[3:0], n, z, v, c} from the requirements.
    function automatic logic [24:0] model(input logic [3:0] o, input int x16,
                                          input int c, input bit b);
        int mask, msb, x, r, v, cc, n, z, we, rw, full;
        mask = b ? 'hFF : 'hFFFF;
        msb  = b ? 'h80 : 'h8000;
        x = x16 & mask;
        r = x; v = 0; cc = 0; we = 'hF; rw = 1;
        case (o)
            4'h0: r = 0;
            4'h1: begin r = (~x) & mask; cc = 1; end
            4'h2: begin r = (x + 1) & mask; v = (r == msb); we = 'hE; end
            4'h3: begin r = (x + mask) & mask; v = (r == msb - 1); we = 'hE; end
            4'h4: begin r = (mask + 1 - x) & mask; v = (r == msb); cc = (r != 0); end
            4'h5: begin r = (x + c) & mask; v = (r == msb) && c; cc = (r == 0) && c; end
            4'h6: begin r = (x - c + mask + 1) & mask; v = (x == msb) && c; cc = (x == 0) && c; end
            4'h7: rw = 0;
            4'h8: begin r = (x >> 1) | (c ? msb : 0); cc = x & 1; end
            4'h9: begin r = ((x << 1) & mask) | c; cc = (x & msb) != 0; end
            4'hA: begin r = (x >> 1) | (x & msb); cc = x & 1; end
            4'hB: begin r = (x << 1) & mask; cc = (x & msb) != 0; end
            default: begin we = 0; rw = 0; end
        endcase
        n = (we != 0) && ((r & msb) != 0);
        z = (we != 0) && (r == 0);
        if (o[3:2] == 2'd2) v = (n != 0) ^ (cc != 0);
        full = b ? ((x16 & 'hFF00) | r) : r;
        return {full[15:0], rw[0], we[3:0], n[0], z[0], v[0], cc[0]};
    endfunction

    task automatic apply(input logic [3:0] o, input int x16, input bit c, input bit b);
        logic [24:0] exp_v, got;
        @(posedge clk);
        op = o; operand = x16[15:0]; carry = c; bmode = b;
        @(negedge clk);
        exp_v = model(o, x16 & 'hFFFF, int'(c), b);
        got = {result, rwe, fwe, fn, fz, fv, fc};
        n_checks++;
        if (got !== exp_v) begin
            n_errors++;
            $display("FAIL %s op=%h x=%h c=%0d b=%0d actual=%h expected=%h",
                     req_of(o, b), o, x16[15:0], c, b, got, exp_v);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        int lfsr;
        int specials [12] = '{'h0000, 'h0001, 'h7FFF, 'h8000, 'h8001, 'hFFFF,
                              'hFFFE, 'h7FFE, 'h00FF, 'hFF00, 'h5555, 'hAAAA};
        operand = '0; carry = 0; bmode = 0; op = 4'h0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1: clear of an all-ones word first.
        apply(4'h0, 'hFFFF, 1'b1, 1'b0);
        // R11, R13 and all ops: every low byte in byte mode.
        lfsr = 'hACE1;
        for (int o = 0; o < 16; o++)
            for (int cv = 0; cv < 2; cv++)
                for (int xb = 0; xb < 256; xb++) begin
                    lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
                    apply(o[3:0], (lfsr & 'hFF00) | xb, cv[0], 1'b1);
                end
        // Word mode: boundary values for R3..R6 plus pseudo-random words.
        for (int o = 0; o < 16; o++)
            for (int cv = 0; cv < 2; cv++) begin
                foreach (specials[i]) apply(o[3:0], specials[i], cv[0], 1'b0);
                for (int k = 0; k < 48; k++) begin
                    lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
                    apply(o[3:0], lfsr, cv[0], 1'b0);
                end
            end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule